// File: doc/BRIEF.md
# Floating-Point Compare and Condition-Flag Unit

This block compares two IEEE-754 operands, in either single or double precision, and turns the result into one condition-flag bit. An 8-bit operation code selects three things: the precision, the relation, and whether an unordered operand pair (at least one NaN) counts against the relation or in its favour. The compare logic itself is purely combinational. The only storage is the flag register, which is loaded on the clock edge where the valid strobe is high and the code is recognised. The unit writes no data result.

On the cycle after an accepted compare, a one-cycle write pulse marks that the flag was loaded. An invalid-operation pulse can accompany it. Signalling NaNs always raise the invalid pulse. Quiet NaNs raise it only for the ordered magnitude relations. A code that is not recognised leaves the flag as it was and produces no pulse.

Top module: `fcmp_flag_unit`

## Requirements
- R1: The code fields are decoded as follows.
  - Bits [7:6] must be 00 and bit 3 must be 1.
  - Bit 4 selects the format: 1 means double, using all 64 bits of each operand; 0 means single, using bits [31:0] only.
  - Bit 5 selects the unordered-or family.
  - Bits [2:0] select the relation: 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le, and 6 unordered-only, which is legal only when bit 5 is 1.
- R2: `flag_q` takes its new value at the rising edge where `op_valid` is high and the code is recognised. `flag_we` is high for exactly the following cycle.
- R3: For non-NaN operands, including infinities and mixed signs, the ordered relations follow numeric order.
- R4: +0 and -0 compare as equal, and neither is less than the other.
- R5: Every ordered relation, ne included, yields 0 when either operand is NaN.
- R6: In the unordered-or family (codes 0x28-0x2d single, 0x38-0x3d double), the flag is (either operand is NaN) OR (the ordered relation holds).
- R7: Codes 0x2e (single) and 0x3e (double) set the flag to 1 exactly when at least one operand is NaN.
- R8: A signalling NaN (exponent all ones, nonzero fraction, top fraction bit 0) raises `invalid` on any recognised code.
- R9: A quiet NaN (top fraction bit 1) raises `invalid` only for the ordered gt, ge, lt and le codes. It does not raise `invalid` for ordered eq or ne, or for any code in the unordered-or family.
- R10: An unrecognised code with `op_valid` high leaves `flag_q` unchanged and keeps both `flag_we` and `invalid` low.
- R11: While reset is active (`rst_n` low), `flag_q`, `flag_we` and `invalid` are all 0.
- R12: `invalid` is a one-cycle pulse that is high only in a cycle where `flag_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Compare request strobe |
| op_code | input | 8 | Compare operation code |
| opnd_a | input | 64 | First operand (single uses bits [31:0]) |
| opnd_b | input | 64 | Second operand (single uses bits [31:0]) |
| flag_q | output | 1 | Condition flag register |
| flag_we | output | 1 | Pulse: flag was written last edge |
| invalid | output | 1 | Pulse: invalid-operation for that write |

## Verification
The bench aims at the corner cases where sign and NaN handling tend to go wrong, each with an expected failure symptom:
- Comparing +0 with -0 catches a bitwise compare, which would report them unequal and call -0 smaller.
- Pairs of negative numbers catch a magnitude compare that forgets to invert order for negatives.
- ne with a NaN operand catches a design that builds ne as the plain inverse of eq, which would wrongly return 1.

The remaining checks cover NaN kinds, code decoding and flag retention:
- Quiet and signalling NaNs are driven under every code family, to catch an `invalid` pulse raised under the wrong codes or missed under the right ones.
- Illegal codes follow a write of 1 to the flag; a design that decodes too loosely would overwrite the flag.
- Single-precision compares carry junk in the upper operand halves, to catch a precision selection that reads the wrong bits.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_GT  = 3'd2,
        REL_GE  = 3'd3,
        REL_LT  = 3'd4,
        REL_LE  = 3'd5,
        REL_UN  = 3'd6,
        REL_BAD = 3'd7
    } rel_e;

    localparam int NUM_FMT = 2;

    function automatic int fmt_exp_w(input int f);
        return (f == 0) ? 8 : 11;
    endfunction

    function automatic int fmt_man_w(input int f);
        return (f == 0) ? 23 : 52;
    endfunction
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
    import fcmp_pkg::*;
(
    input  logic [7:0] code,
    output logic       legal,
    output logic       is_dbl,
    output logic       unord_fam,
    output rel_e       rel
);
    logic base_ok;

    always_comb begin
        rel       = rel_e'(code[2:0]);
        is_dbl    = code[4];
        unord_fam = code[5];
        base_ok   = (code[7:6] == 2'b00) && code[3];
        unique case (rel)
            REL_EQ, REL_NE, REL_GT,
            REL_GE, REL_LT, REL_LE: legal = base_ok;
            REL_UN:                 legal = base_ok && unord_fam;
            default:                legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = EXP_W + MAN_W + 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         unord,
    output logic         any_snan,
    output logic         any_qnan,
    output logic         eq,
    output logic         lt
);
    logic [W-2:0] mag_a, mag_b;
    logic         nan_a, nan_b, both_zero;

    always_comb begin
        mag_a     = a[W-2:0];
        mag_b     = b[W-2:0];
        nan_a     = (&a[W-2 -: EXP_W]) && (|a[MAN_W-1:0]);
        nan_b     = (&b[W-2 -: EXP_W]) && (|b[MAN_W-1:0]);
        unord     = nan_a || nan_b;
        any_snan  = (nan_a && !a[MAN_W-1]) || (nan_b && !b[MAN_W-1]);
        any_qnan  = (nan_a && a[MAN_W-1]) || (nan_b && b[MAN_W-1]);
        both_zero = (mag_a == '0) && (mag_b == '0);
        eq        = both_zero || (a == b);
        if (both_zero)
            lt = 1'b0;
        else if (a[W-1] != b[W-1])
            lt = a[W-1];
        else if (!a[W-1])
            lt = mag_a < mag_b;
        else
            lt = mag_a > mag_b;
    end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
    import fcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [7:0]  op_code,
    input  logic [63:0] opnd_a,
    input  logic [63:0] opnd_b,
    output logic        flag_q,
    output logic        flag_we,
    output logic        invalid
);
    logic legal, is_dbl, unord_fam;
    rel_e rel;

    logic [NUM_FMT-1:0] f_unord, f_snan, f_qnan, f_eq, f_lt;

    fcmp_decode dec_i (
        .code      (op_code),
        .legal     (legal),
        .is_dbl    (is_dbl),
        .unord_fam (unord_fam),
        .rel       (rel)
    );

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int EW = fmt_exp_w(f);
        localparam int MW = fmt_man_w(f);
        localparam int FW = EW + MW + 1;
        fcmp_order #(.EXP_W(EW), .MAN_W(MW)) ord_i (
            .a        (opnd_a[FW-1:0]),
            .b        (opnd_b[FW-1:0]),
            .unord    (f_unord[f]),
            .any_snan (f_snan[f]),
            .any_qnan (f_qnan[f]),
            .eq       (f_eq[f]),
            .lt       (f_lt[f])
        );
    end

    logic unord, snan, qnan, eq, lt, rel_hit, mag_rel;
    logic flag_c, inv_c, do_write;

    always_comb begin
        unord   = f_unord[is_dbl];
        snan    = f_snan[is_dbl];
        qnan    = f_qnan[is_dbl];
        eq      = f_eq[is_dbl];
        lt      = f_lt[is_dbl];
        mag_rel = 1'b0;
        unique case (rel)
            REL_EQ:  rel_hit = eq;
            REL_NE:  rel_hit = !eq;
            REL_GT:  begin rel_hit = !eq && !lt; mag_rel = 1'b1; end
            REL_GE:  begin rel_hit = !lt;        mag_rel = 1'b1; end
            REL_LT:  begin rel_hit = lt;         mag_rel = 1'b1; end
            REL_LE:  begin rel_hit = lt || eq;   mag_rel = 1'b1; end
            default: rel_hit = 1'b0;
        endcase
        if (rel == REL_UN)
            flag_c = unord;
        else if (unord_fam)
            flag_c = unord || rel_hit;
        else
            flag_c = !unord && rel_hit;
        inv_c    = snan || (qnan && !unord_fam && mag_rel);
        do_write = op_valid && legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            flag_we <= 1'b0;
            invalid <= 1'b0;
        end else begin
            flag_we <= do_write;
            invalid <= do_write && inv_c;
            if (do_write)
                flag_q <= flag_c;
        end
    end
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [7:0]  op_code,
    input logic [31:0] a_lo,
    input logic [31:0] b_lo,
    input logic        flag_q,
    input logic        flag_we,
    input logic        invalid
);
    assert_we_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> $past(op_valid));

    assert_flag_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |-> $stable(flag_q));

    assert_bad_code_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[2:0] == 3'd7) |=> (!flag_we && !invalid));

    assert_invalid_with_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> flag_we);

    assert_identical_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 8'h08 && a_lo == b_lo && a_lo[30:23] != 8'hFF) |=> flag_q);

    assert_signed_zero_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 8'h08 && a_lo == 32'h0 && b_lo == 32'h8000_0000) |=> flag_q);

    assert_unord_only_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 8'h2e && a_lo[30:23] != 8'hFF && b_lo[30:23] != 8'hFF) |=> !flag_q);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .a_lo     (opnd_a[31:0]),
    .b_lo     (opnd_b[31:0]),
    .flag_q   (flag_q),
    .flag_we  (flag_we),
    .invalid  (invalid)
);

// File: tb/fcmp_flag_unit_tb_top.sv
module fcmp_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        flag_q, flag_we, invalid;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_q(flag_q), .flag_we(flag_we), .invalid(invalid)
    );

    typedef struct {
        logic  flag;
        logic  we;
        logic  inv;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    logic  model_flag = 1'b0;
    bit    run_done = 1'b0;

    function automatic real sp_to_real(input logic [31:0] v);
        real m;
        int  e;
        e = int'(v[30:23]);
        if (e == 255) m = 1.0e300;
        else if (e == 0) m = real'(v[22:0]) / 8388608.0 * (2.0 ** -126);
        else m = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return v[31] ? -m : m;
    endfunction

    task automatic model(input logic [7:0] c, input logic [63:0] a, input logic [63:0] b,
                         output logic legal, output logic flag, output logic inv);
        logic dbl, fam, na, nb, qa, qb, un, ord;
        logic [2:0] r;
        real ra, rb;
        dbl = c[4]; fam = c[5]; r = c[2:0];
        legal = (c[7:6] == 2'b00) && c[3] && ((r <= 3'd5) || (r == 3'd6 && fam));
        if (dbl) begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0); qa = a[51];
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0); qb = b[51];
            ra = $bitstoreal(a); rb = $bitstoreal(b);
        end else begin
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0); qa = a[22];
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0); qb = b[22];
            ra = sp_to_real(a[31:0]); rb = sp_to_real(b[31:0]);
        end
        un = na || nb;
        ord = 1'b0;
        if (!un) begin
            case (r)
                3'd0: ord = (ra == rb);
                3'd1: ord = (ra != rb);
                3'd2: ord = (ra > rb);
                3'd3: ord = (ra >= rb);
                3'd4: ord = (ra < rb);
                3'd5: ord = (ra <= rb);
                default: ord = 1'b0;
            endcase
        end
        if (r == 3'd6) flag = un;
        else if (fam)  flag = un || ord;
        else           flag = ord;
        inv = (na && !qa) || (nb && !qb) ||
              (((na && qa) || (nb && qb)) && !fam && r >= 3'd2 && r <= 3'd5);
    endtask

    task automatic apply(input logic v, input logic [7:0] c, input logic [63:0] a,
                         input logic [63:0] b, input string tag);
        exp_t e;
        logic legal, fl, inv;
        @(negedge clk);
        op_valid = v; op_code = c; opnd_a = a; opnd_b = b;
        model(c, a, b, legal, fl, inv);
        if (v && legal) begin
            model_flag = fl;
            e.we = 1'b1; e.inv = inv;
        end else begin
            e.we = 1'b0; e.inv = 1'b0;
        end
        e.flag = model_flag; e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        exp_t e;
        #3;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_vec++;
            if (flag_q !== e.flag || flag_we !== e.we || invalid !== e.inv) begin
                n_fail++;
                $display("FAIL %s: flag/we/inv actual %b%b%b expected %b%b%b",
                         e.tag, flag_q, flag_we, invalid, e.flag, e.we, e.inv);
            end
        end
    end

    localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000,
        S_M1 = 32'hBF80_0000, S_M2 = 32'hC000_0000, S_PZ = 32'h0, S_MZ = 32'h8000_0000,
        S_QN = 32'h7FC0_0000, S_SN = 32'h7FA0_0000, S_INF = 32'h7F80_0000, S_MINF = 32'hFF80_0000;
    localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000,
        D_M1 = 64'hBFF0_0000_0000_0000, D_MZ = 64'h8000_0000_0000_0000,
        D_QN = 64'h7FF8_0000_0000_0000, D_SN = 64'h7FF4_0000_0000_0000,
        D_INF = 64'h7FF0_0000_0000_0000, D_TINY = 64'h0000_0000_0000_0001;

    initial begin
        logic [31:0] sa [10];
        logic [31:0] sb [10];
        logic [63:0] da [8];
        logic [63:0] db [8];
        logic [7:0]  bad [6];
        sa = '{S_ONE, S_TWO, S_M2, S_M1, S_PZ, S_MINF, S_QN, S_ONE, S_SN, S_INF};
        sb = '{S_TWO, S_ONE, S_M1, S_ONE, S_MZ, S_M1,  S_ONE, S_QN, S_ONE, S_INF};
        da = '{D_ONE, D_TWO, D_M1, 64'h0, D_QN, D_SN, D_INF, D_TINY};
        db = '{D_TWO, D_ONE, D_ONE, D_MZ, D_ONE, D_TWO, D_ONE, 64'h0};
        bad = '{8'h0e, 8'h0f, 8'h2f, 8'h48, 8'h88, 8'h07};

        repeat (3) @(negedge clk);
        n_vec++;
        if (flag_q !== 1'b0 || flag_we !== 1'b0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: reset outputs actual %b%b%b expected 000", flag_q, flag_we, invalid);
        end
        rst_n = 1'b1;

        // R3 R4 R5 R9 R8 R1: single ordered, junk in upper halves
        for (int p = 0; p < 10; p++)
            for (int r = 0; r < 6; r++)
                apply(1'b1, 8'h08 + 8'(r), {32'hDEAD_BEEF, sa[p]}, {32'h1234_5678, sb[p]}, "R3/R4/R5/R8/R9/R1");
        // R6 R7: unordered-or family and unordered-only, single
        for (int p = 0; p < 10; p++)
            for (int r = 0; r < 7; r++)
                apply(1'b1, 8'h28 + 8'(r), {32'h0, sa[p]}, {32'h0, sb[p]}, "R6/R7/R9");
        // R12 R1: double precision, both families
        for (int p = 0; p < 8; p++) begin
            for (int r = 0; r < 6; r++)
                apply(1'b1, 8'h18 + 8'(r), da[p], db[p], "R12/R3/R5/R8");
            for (int r = 0; r < 7; r++)
                apply(1'b1, 8'h38 + 8'(r), da[p], db[p], "R12/R6/R7");
        end
        // R10: illegal codes after flag set to 1 and then to 0
        for (int k = 0; k < 6; k++) begin
            apply(1'b1, 8'h08, {32'h0, S_ONE}, {32'h0, S_ONE}, "R2");
            apply(1'b1, bad[k], {32'h0, S_ONE}, {32'h0, S_TWO}, "R10");
            apply(1'b1, 8'h09, {32'h0, S_ONE}, {32'h0, S_ONE}, "R2");
            apply(1'b1, bad[k], {32'h0, S_QN}, {32'h0, S_SN}, "R10");
        end
        // R2: no valid means no write
        apply(1'b1, 8'h2e, {32'h0, S_QN}, {32'h0, S_ONE}, "R7");
        apply(1'b0, 8'h08, {32'h0, S_ONE}, {32'h0, S_TWO}, "R2");
        apply(1'b0, 8'h0c, {32'h0, S_SN}, {32'h0, S_TWO}, "R2");
        apply(1'b0, 8'h00, '0, '0, "R2");
        apply(1'b0, 8'h00, '0, '0, "R2");
        while (sb_q.size() > 0) @(posedge clk);
        #5;
        run_done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!run_done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule